// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Mode Controller

This block is the control core of a 16-bit-wide one-time-programmable read-only memory, written as a synthesizable device model. It takes the active-low chip-select, output-enable and program-strobe pins, two flags for analog conditions, and the word address. The flags report the programming supply and the raised identifier voltage on the address pin. From these it picks one operating mode. Depending on that mode, the output bus carries a stored word, a fixed identifier, or floats, or the input bus is burned into the array.

The array is an inferred single-port RAM with a narrow address for simulation. A word is programmed on a sampled falling edge of the program strobe, and programming can only clear bits. An erase request, and also reset, start a sweep that sets every word back to all ones, one word per cycle. While the identifier voltage is present, the block returns a manufacturer code or a device code, chosen by address bit 0. Bit 7 of each code is computed as an odd-parity bit. If the other address bits are not zero during identifier readout, the block flags a protocol error.

Top module: `prom_ctrl`

## Requirements
- R1: With chip-select and output-enable low, no identifier voltage and no active program strobe, `dout` carries the word stored at `addr` and `dout_oe` is 1. Outputs are registered and show a stable input two clock edges after it is applied.
- R2: While `chip_en_n` is high, `dout_oe` is 0 regardless of every other input. This covers standby and program-inhibit.
- R3: With `chip_en_n` low and `out_en_n` high, `dout_oe` is 0.
- R4: With `vpp_hv` high, `chip_en_n` low and `out_en_n` high, a 1-to-0 transition of `prog_n` seen on consecutive clock edges replaces the word at `addr` with (old word AND `din`). Programming never sets a bit to 1.
- R5: A `prog_n` falling edge leaves the array unchanged if any of these holds at that edge: `out_en_n` is low, `vpp_hv` is low, or `chip_en_n` is high.
- R6: With `vpp_hv` high, `chip_en_n` and `out_en_n` low and `prog_n` high, the stored word at `addr` is driven (verify).
- R7: With `id_hv` high, `chip_en_n` and `out_en_n` low and `addr[ADDR_W-1:1]` all zero, `dout` is 16'h0001 when `addr[0]` is 0 (manufacturer) and 16'h008C when `addr[0]` is 1 (device), and `proto_err` is 0.
- R8: Every identifier word has zeros in bits 15:8, and bits 7:0 hold an odd number of ones, with bit 7 as the parity bit.
- R9: In identifier readout with any of `addr[ADDR_W-1:1]` set, `dout` is all ones, `dout_oe` is 1 and `proto_err` is 1. `proto_err` is 0 in all other modes.
- R10: Reset or an `erase` pulse sets all 2^ADDR_W words to 16'hFFFF within 2^ADDR_W cycles. During the sweep `dout_oe` is 0 and programming is ignored.
- R11: While `rst` is high, the next edge clears `dout`, `dout_oe` and `proto_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts an erase sweep |
| chip_en_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output gate |
| prog_n | input | 1 | Active-low program strobe |
| vpp_hv | input | 1 | Programming supply present |
| id_hv | input | 1 | Identifier voltage present on the address pin |
| erase | input | 1 | Starts a sweep that sets every word to all ones |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data to program |
| dout | output | DATA_W | Output data |
| dout_oe | output | 1 | Output drive enable (0 means high impedance) |
| proto_err | output | 1 | Identifier readout with a nonzero upper address |

## Verification
A wrong mode decode shows up on `dout_oe` two edges after the offending input: a floating bus where a word is expected, or the reverse. A stuck or mistimed edge detector on the program strobe, or a read-modify-write that loses the old word, only appears on a later read of that address. The bench therefore reads every address back after each programming pass. A broken erase sweep leaves non-FFFF words, which the full-array read after each sweep exposes. A wrong parity or code selection shows at once on the identifier sweep over all addresses.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [2:0] {
    MD_FLOAT  = 3'd0,
    MD_READ   = 3'd1,
    MD_VERIFY = 3'd2,
    MD_ID     = 3'd3,
    MD_PROG   = 3'd4
  } prom_mode_e;

  // bit 7 chosen so that the 8-bit code has an odd number of ones
  function automatic logic [7:0] odd_par_code(input logic [6:0] payload);
    return {~(^payload), payload};
  endfunction
endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
  import prom_pkg::*;
(
  input  logic       busy,
  input  logic       chip_en_n,
  input  logic       out_en_n,
  input  logic       prog_n,
  input  logic       prog_prev,
  input  logic       vpp_hv,
  input  logic       id_hv,
  output prom_mode_e mode,
  output logic       burn
);
  always_comb begin
    if (busy || chip_en_n)        mode = MD_FLOAT;
    else if (vpp_hv && !prog_n)   mode = MD_PROG;
    else if (out_en_n)            mode = MD_FLOAT;
    else if (id_hv)               mode = MD_ID;
    else if (vpp_hv)              mode = MD_VERIFY;
    else                          mode = MD_READ;
  end

  // a write fires only on a sampled strobe fall with the output gate off
  assign burn = (mode == MD_PROG) && prog_prev && out_en_n;
endmodule

// File: rtl/prom_array.sv
module prom_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_bits,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] sweep_ptr;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_bits;

  // sweep and pending-write control
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b1;
      sweep_ptr <= '0;
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_bits <= '0;
    end else begin
      pend_v <= wr_req && !busy;
      if (wr_req && !busy) begin
        pend_addr <= addr;
        pend_bits <= wr_bits;
      end
      if (busy) begin
        sweep_ptr <= sweep_ptr + 1'b1;
        if (sweep_ptr == ADDR_W'(DEPTH - 1)) busy <= 1'b0;
      end else if (erase_req) begin
        busy      <= 1'b1;
        sweep_ptr <= '0;
      end
    end
  end

  // RAM: one write port, registered read (read-first)
  always_ff @(posedge clk) begin
    if (busy)
      mem[sweep_ptr] <= '1;
    else if (pend_v)
      mem[pend_addr] <= rd_data & pend_bits;
    rd_data <= mem[addr];
  end
endmodule

// File: rtl/prom_id_code.sv
module prom_id_code
  import prom_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter logic [6:0]  MFR_PAY = 7'h01,
  parameter logic [6:0]  DEV_PAY = 7'h0C
) (
  input  logic              sel_dev,
  output logic [DATA_W-1:0] code
);
  localparam logic [7:0] MFR_CODE = odd_par_code(MFR_PAY);
  localparam logic [7:0] DEV_CODE = odd_par_code(DEV_PAY);

  assign code = DATA_W'(sel_dev ? DEV_CODE : MFR_CODE);
endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage
  import prom_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  prom_mode_e        mode_q,
  input  logic              addr_bad_q,
  input  logic [DATA_W-1:0] word_q,
  input  logic [DATA_W-1:0] id_q,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              proto_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= '0;
      dout_oe   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= 1'b0;
      unique case (mode_q)
        MD_READ, MD_VERIFY: begin
          dout    <= word_q;
          dout_oe <= 1'b1;
        end
        MD_ID: begin
          dout      <= addr_bad_q ? '1 : id_q;
          dout_oe   <= 1'b1;
          proto_err <= addr_bad_q;
        end
        default: begin
          dout    <= '0;
          dout_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/prom_ctrl.sv
module prom_ctrl
  import prom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              prog_n,
  input  logic              vpp_hv,
  input  logic              id_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              proto_err
);
  prom_mode_e        mode_now, mode_q;
  logic              burn, prog_prev, sweep_busy;
  logic              addr_bad_q;
  logic [DATA_W-1:0] word_q, id_now, id_q;

  always_ff @(posedge clk) begin
    if (rst) prog_prev <= 1'b1;
    else     prog_prev <= prog_n;
  end

  prom_mode_decode u_dec (
    .busy(sweep_busy), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .prog_n(prog_n), .prog_prev(prog_prev), .vpp_hv(vpp_hv),
    .id_hv(id_hv), .mode(mode_now), .burn(burn)
  );

  prom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst(rst), .erase_req(erase), .addr(addr),
    .wr_req(burn), .wr_bits(din), .rd_data(word_q), .busy(sweep_busy)
  );

  prom_id_code #(.DATA_W(DATA_W)) u_id (
    .sel_dev(addr[0]), .code(id_now)
  );

  // first stage: mode and identifier, aligned with the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MD_FLOAT;
      addr_bad_q <= 1'b0;
      id_q       <= '0;
    end else begin
      mode_q     <= mode_now;
      addr_bad_q <= |addr[ADDR_W-1:1];
      id_q       <= id_now;
    end
  end

  prom_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .mode_q(mode_q), .addr_bad_q(addr_bad_q),
    .word_q(word_q), .id_q(id_q), .dout(dout), .dout_oe(dout_oe),
    .proto_err(proto_err)
  );
endmodule

// File: rtl/prom_ctrl_chk.sv
module prom_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_en_n,
  input logic              out_en_n,
  input logic              id_hv,
  input logic              sweep_busy,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic              proto_err
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  a_r2_standby_float: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(chip_en_n, 2)) |-> !dout_oe);

  a_r3_gate_off_float: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(!chip_en_n && out_en_n, 2)) |-> !dout_oe);

  a_r8_id_parity: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(id_hv, 2) && dout_oe && !proto_err)
      |-> (dout[DATA_W-1:8] == '0 && $countones(dout[7:0]) % 2 == 1));

  a_r9_err_ones: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> (dout_oe && dout == '1));

  a_r10_sweep_float: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(sweep_busy, 2)) |-> !dout_oe);

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!dout_oe && !proto_err && dout == '0));
endmodule

bind prom_ctrl prom_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
  .id_hv(id_hv), .sweep_busy(sweep_busy), .dout(dout),
  .dout_oe(dout_oe), .proto_err(proto_err)
);

// File: tb/prom_ctrl_test.sv
module prom_ctrl_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chip_en_n = 1'b1, out_en_n = 1'b1, prog_n = 1'b1;
  logic          vpp_hv = 1'b0, id_hv = 1'b0, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe, proto_err;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [N];

  always #5 clk = ~clk;

  prom_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .prog_n(prog_n), .vpp_hv(vpp_hv), .id_hv(id_hv), .erase(erase),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive pins at a falling edge, let two rising edges pass, sample at the next fall
  task automatic apply(input logic ce, input logic oe, input logic pg,
                       input logic vp, input logic idv, input logic [AW-1:0] a);
    @(negedge clk);
    chip_en_n = ce; out_en_n = oe; prog_n = pg; vpp_hv = vp; id_hv = idv; addr = a;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic burn(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic ce, input logic oe, input logic vp);
    @(negedge clk);
    chip_en_n = ce; out_en_n = oe; vpp_hv = vp; id_hv = 1'b0; prog_n = 1'b1;
    addr = a; din = d;
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chip_en_n = 1'b1; out_en_n = 1'b1; vpp_hv = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < N; a++) begin
      apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(a));
      chk(req, {15'd0, dout_oe}, 16'd1);
      chk(req, dout, model[a]);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a * 16'h1357 + k * 16'h2c1) ^ 16'hA5A5;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", {dout_oe, proto_err, 14'd0}, 16'd0);
    chk("R11", dout, 16'd0);
    rst = 1'b0;
    repeat (N + 4) @(posedge clk);
    for (int a = 0; a < N; a++) model[a] = '1;
    read_all("R10");                       // R10: array blank after reset sweep

    for (int a = 0; a < N; a++) begin      // R4: first pass from blank
      burn(AW'(a), pat(a, 1), 1'b0, 1'b1, 1'b1);
      model[a] = model[a] & pat(a, 1);
    end
    read_all("R1");
    for (int a = 0; a < N; a += 3) begin   // R4: second pass only clears bits
      burn(AW'(a), pat(a, 7), 1'b0, 1'b1, 1'b1);
      model[a] = model[a] & pat(a, 7);
    end
    read_all("R4");

    // R5: strobe fall with output gate low, no supply, or deselected
    for (int a = 0; a < N; a += 5) begin
      burn(AW'(a), 16'h0000, 1'b0, 1'b0, 1'b1);
      burn(AW'(a), 16'h0000, 1'b0, 1'b1, 1'b0);
      burn(AW'(a), 16'h0000, 1'b1, 1'b1, 1'b1);
    end
    read_all("R5");

    // R6: verify with supply present
    for (int a = 0; a < N; a += 7) begin
      apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(a));
      chk("R6", {15'd0, dout_oe}, 16'd1);
      chk("R6", dout, model[a]);
    end

    // R2 and R3: every control combination that must float
    for (int c = 0; c < 16; c++) begin
      apply(1'b1, c[0], c[1], c[2], c[3], AW'(c));
      chk("R2", {15'd0, dout_oe}, 16'd0);
      apply(1'b0, 1'b1, 1'b1, c[2], c[3], AW'(c));
      chk("R3", {15'd0, dout_oe}, 16'd0);
    end

    // R7, R8, R9: identifier sweep over every address
    for (int a = 0; a < N; a++) begin
      logic [DW-1:0] exp;
      apply(1'b0, 1'b0, 1'b1, a[0], 1'b1, AW'(a));
      if ((a >> 1) == 0) begin
        exp = a[0] ? 16'h008C : 16'h0001;
        chk("R7", dout, exp);
        chk("R7", {15'd0, proto_err}, 16'd0);
        chk("R8", {15'd0, ^dout[7:0]}, 16'd1);
      end else begin
        chk("R9", dout, 16'hFFFF);
        chk("R9", {14'd0, dout_oe, proto_err}, 16'd3);
      end
    end
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(2));
    chk("R9", {15'd0, proto_err}, 16'd0);

    // R10: erase pulse, outputs float during sweep, burns ignored
    @(negedge clk);
    chip_en_n = 1'b0; out_en_n = 1'b0; vpp_hv = 1'b0; id_hv = 1'b0; addr = '0;
    erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", {15'd0, dout_oe}, 16'd0);
    burn(AW'(4), 16'h0000, 1'b0, 1'b1, 1'b1);
    repeat (N + 4) @(posedge clk);
    for (int a = 0; a < N; a++) model[a] = '1;
    read_all("R10");

    // R11: reset while driving
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(1));
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R11", {dout_oe, proto_err, 14'd0}, 16'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule